// File: doc/BRIEF.md
# Sixteen-Bit Multi-Cycle Processor Datapath

This block holds the storage and arithmetic of a small 16-bit processor that runs each instruction over several clock cycles. A single memory array serves both instruction fetch and data access, and a single ALU does all the arithmetic. It adds the operands of an instruction, and it also advances the program counter and forms branch targets. Between cycles, values are held in intermediate registers: the instruction register, the memory data register, the two operand registers and the result register. A separate controller, not part of this block, drives the per-cycle select and enable inputs. It reads back the opcode of the current instruction and three signed comparison flags.

An instruction word has four 4-bit fields. From the top they are the opcode (bits 15:12), the first source register (11:8), the second source or I-type destination (7:4), and the R-type destination or 4-bit immediate (3:0). A jump carries a 12-bit absolute target in bits 11:0. The memory also has an initialisation write port, so that code and data can be placed in it before or between instructions.

Top module: `mc16_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, instruction register, memory data register, both operand registers and the result register to zero, so `opcode` reads 0 and `flag_eq` reads 1 on the cycle after reset.
- R2: While `ir_load` is high, the instruction register captures the memory read word on the clock edge, and `opcode` then shows its bits 15:12. While `ir_load` is low, the instruction register holds its value.
- R3: While `pc_load` is high, the program counter takes the value chosen by `pc_next_sel`. The value 00 selects the ALU result of the current cycle, 01 the result register, and 10 the instruction bits 11:0 zero-extended to 16 bits. While `pc_load` is low, the program counter holds.
- R4: `alu_fn` selects the ALU operation: 00 add, 01 subtract (first minus second), 10 bitwise AND, 11 bitwise OR. Results wrap modulo 2^16, and the result register captures the ALU output on every edge.
- R5: The first ALU operand is the program counter when `opa_from_reg` is 0 and the first operand register when it is 1. `opb_sel` selects the second operand: 00 the second operand register, 01 the constant 1, and 10 or 11 the instruction bits 3:0 sign-extended to 16 bits.
- R6: On every edge, the first operand register loads register-file entry IR[11:8] and the second loads entry IR[7:4]. A register-file write goes to IR[3:0] when `dst_from_rd` is 1 and to IR[7:4] when it is 0. Register 0 always reads as zero.
- R7: The memory address is PC[7:0] when `addr_from_res` is 0 and the low 8 bits of the result register when it is 1. `mem_rdata` shows the word at that address without a clock. While `mem_wr` is high, the second operand register is written there on the edge.
- R8: `flag_eq`, `flag_lt` and `flag_gt` report a two's-complement comparison of the first operand register against the second, and exactly one of the three is high.
- R9: The memory data register captures `mem_rdata` on every edge. With `wb_from_mdr` set to 1, the register file is written from it; with 0, from the result register.
- R10: While `init_wr` is high, `init_data` is written to `init_addr`, and this write takes priority over a `mem_wr` write in the same cycle.
- R11: A cycle with every enable low (`pc_load`, `ir_load`, `rf_wr`, `mem_wr`, `init_wr`) changes neither the program counter, the instruction register, the register file nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_load | input | 1 | Program counter write enable |
| addr_from_res | input | 1 | Memory address from result register (1) or PC (0) |
| mem_wr | input | 1 | Memory write enable for the datapath store |
| ir_load | input | 1 | Instruction register write enable |
| rf_wr | input | 1 | Register file write enable |
| dst_from_rd | input | 1 | Destination field IR[3:0] (1) or IR[7:4] (0) |
| wb_from_mdr | input | 1 | Write-back from memory data register (1) or result register (0) |
| opa_from_reg | input | 1 | First ALU operand: operand register (1) or PC (0) |
| opb_sel | input | 2 | Second ALU operand select |
| pc_next_sel | input | 2 | Next program counter select |
| alu_fn | input | 2 | ALU operation select |
| init_wr | input | 1 | Initialisation write enable |
| init_addr | input | 8 | Initialisation write address |
| init_data | input | 16 | Initialisation write data |
| opcode | output | 4 | Bits 15:12 of the instruction register |
| flag_eq | output | 1 | First operand equals second |
| flag_lt | output | 1 | First operand less than second, signed |
| flag_gt | output | 1 | First operand greater than second, signed |
| pc_o | output | 16 | Program counter |
| result_o | output | 16 | Result register |
| mem_rdata | output | 16 | Memory word at the current address |

## Verification
Two functions share one clock edge. During fetch, the memory is read at the old PC into the instruction register while the shared ALU computes PC+1 and the PC loads it. During a taken branch, the PC loads the target held in the result register while the ALU overwrites that register with the comparison subtraction. The bench acts as the controller for random instruction streams that hit both situations, including jumps and branches with positive and negative offsets. After every such edge it compares the new PC, the opcode and the result against a bench model, which shows whether each path used the pre-edge or the post-edge value.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    OPB_REG  = 2'b00,
    OPB_ONE  = 2'b01,
    OPB_IMM  = 2'b10,
    OPB_IMMX = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCN_ALU  = 2'b00,
    PCN_RES  = 2'b01,
    PCN_JMP  = 2'b10,
    PCN_ALTX = 2'b11
  } pc_next_e;
endpackage

// File: rtl/mc16_mem.sv
module mc16_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          init_wr,
  input  logic [AW-1:0] init_addr,
  input  logic [DW-1:0] init_data,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic          wen;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdat;

  // initialisation port wins over the datapath store
  always_comb begin
    wen   = init_wr | wr;
    waddr = init_wr ? init_addr : addr;
    wdat  = init_wr ? init_data : wdata;
  end

  always_ff @(posedge clk) begin
    if (wen) store[waddr] <= wdat;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW      = 16,
  parameter int FW      = 4,
  parameter bit R0_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [FW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [FW-1:0] raddr_a,
  input  logic [FW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int NREG = 1 << FW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wr) regs[waddr] <= wdata;
  end

  generate
    if (R0_ZERO) begin : g_zero
      assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
      assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end else begin : g_plain
      assign rdata_a = regs[raddr_a];
      assign rdata_b = regs[raddr_b];
    end
  endgenerate
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  alu_fn_e       fn,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  output logic [DW-1:0] y,
  output logic          eq,
  output logic          lt,
  output logic          gt
);
  always_comb begin
    case (fn)
      FN_ADD:  y = opa + opb;
      FN_SUB:  y = opa - opb;
      FN_AND:  y = opa & opb;
      default: y = opa | opb;
    endcase
  end

  // signed comparison of the two operand registers
  assign eq = (cmp_a == cmp_b);
  assign lt = ($signed(cmp_a) < $signed(cmp_b));
  assign gt = ($signed(cmp_a) > $signed(cmp_b));
endmodule

// File: rtl/mc16_datapath.sv
module mc16_datapath
  import mc16_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_load,
  input  logic          addr_from_res,
  input  logic          mem_wr,
  input  logic          ir_load,
  input  logic          rf_wr,
  input  logic          dst_from_rd,
  input  logic          wb_from_mdr,
  input  logic          opa_from_reg,
  input  logic [1:0]    opb_sel,
  input  logic [1:0]    pc_next_sel,
  input  logic [1:0]    alu_fn,
  input  logic          init_wr,
  input  logic [AW-1:0] init_addr,
  input  logic [DW-1:0] init_data,
  output logic [3:0]    opcode,
  output logic          flag_eq,
  output logic          flag_lt,
  output logic          flag_gt,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] mem_rdata
);
  localparam int FW = DW / 4;
  localparam int JW = 3 * FW;

  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [DW-1:0] rf_a, rf_b, rf_wdata;
  logic [DW-1:0] opa, opb, alu_y, pc_next, imm_ext;
  logic [FW-1:0] f_rs, f_rt, f_lo, rf_waddr;
  logic [AW-1:0] mem_addr;

  assign f_rs    = ir_q[3*FW-1:2*FW];
  assign f_rt    = ir_q[2*FW-1:FW];
  assign f_lo    = ir_q[FW-1:0];
  assign imm_ext = {{(DW-FW){f_lo[FW-1]}}, f_lo};

  assign mem_addr = addr_from_res ? res_q[AW-1:0] : pc_q[AW-1:0];

  mc16_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk       (clk),
    .wr        (mem_wr),
    .addr      (mem_addr),
    .wdata     (b_q),
    .init_wr   (init_wr),
    .init_addr (init_addr),
    .init_data (init_data),
    .rdata     (mem_rdata)
  );

  assign rf_waddr = dst_from_rd ? f_lo : f_rt;
  assign rf_wdata = wb_from_mdr ? mdr_q : res_q;

  mc16_regfile #(.DW(DW), .FW(FW), .R0_ZERO(1'b1)) u_rf (
    .clk     (clk),
    .wr      (rf_wr),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  assign opa = opa_from_reg ? a_q : pc_q;

  always_comb begin
    case (opb_sel_e'(opb_sel))
      OPB_REG: opb = b_q;
      OPB_ONE: opb = {{(DW-1){1'b0}}, 1'b1};
      default: opb = imm_ext;
    endcase
  end

  mc16_alu #(.DW(DW)) u_alu (
    .opa   (opa),
    .opb   (opb),
    .fn    (alu_fn_e'(alu_fn)),
    .cmp_a (a_q),
    .cmp_b (b_q),
    .y     (alu_y),
    .eq    (flag_eq),
    .lt    (flag_lt),
    .gt    (flag_gt)
  );

  always_comb begin
    case (pc_next_e'(pc_next_sel))
      PCN_RES: pc_next = res_q;
      PCN_JMP: pc_next = {{(DW-JW){1'b0}}, ir_q[JW-1:0]};
      default: pc_next = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_next;
      if (ir_load) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      res_q <= alu_y;
    end
  end

  assign opcode   = ir_q[DW-1:DW-4];
  assign pc_o     = pc_q;
  assign result_o = res_q;
endmodule

// File: rtl/mc16_datapath_chk.sv
module mc16_datapath_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_load,
  input logic          ir_load,
  input logic [1:0]    pc_next_sel,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] mdr_q,
  input logic [DW-1:0] res_q,
  input logic [DW-1:0] mem_rdata,
  input logic          flag_eq,
  input logic          flag_lt,
  input logic          flag_gt
);
  localparam int JW = 3 * (DW / 4);

  logic rst_d = 1'b0;

  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert (pc_q == '0 && ir_q == '0 && mdr_q == '0 && res_q == '0);
    end
    rst_d <= rst;
  end

  a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_load |=> $stable(pc_q));

  a_r3_jump_target: assert property (@(posedge clk) disable iff (rst)
    (pc_load && pc_next_sel == 2'b10) |=> (pc_q == {{(DW-JW){1'b0}}, $past(ir_q[JW-1:0])}));

  a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(ir_q));

  a_r2_ir_fetch: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (ir_q == $past(mem_rdata)));

  a_r9_mdr_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mdr_q == $past(mem_rdata)));

  a_r8_flag_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({flag_eq, flag_lt, flag_gt}) == 1);
endmodule

bind mc16_datapath mc16_datapath_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_load     (pc_load),
  .ir_load     (ir_load),
  .pc_next_sel (pc_next_sel),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .mdr_q       (mdr_q),
  .res_q       (res_q),
  .mem_rdata   (mem_rdata),
  .flag_eq     (flag_eq),
  .flag_lt     (flag_lt),
  .flag_gt     (flag_gt)
);

// File: tb/mc16_datapath_test.sv
module mc16_datapath_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        pc_load, addr_from_res, mem_wr, ir_load, rf_wr;
  logic        dst_from_rd, wb_from_mdr, opa_from_reg;
  logic [1:0]  opb_sel, pc_next_sel, alu_fn;
  logic        init_wr;
  logic [7:0]  init_addr;
  logic [15:0] init_data;
  logic [3:0]  opcode;
  logic        flag_eq, flag_lt, flag_gt;
  logic [15:0] pc_o, result_o, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] m_rf  [16];
  logic [15:0] m_mem [256];
  logic [15:0] m_pc;

  always #4 clk = ~clk;

  mc16_datapath uut (
    .clk(clk), .rst(rst), .pc_load(pc_load), .addr_from_res(addr_from_res),
    .mem_wr(mem_wr), .ir_load(ir_load), .rf_wr(rf_wr), .dst_from_rd(dst_from_rd),
    .wb_from_mdr(wb_from_mdr), .opa_from_reg(opa_from_reg), .opb_sel(opb_sel),
    .pc_next_sel(pc_next_sel), .alu_fn(alu_fn), .init_wr(init_wr),
    .init_addr(init_addr), .init_data(init_data), .opcode(opcode),
    .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_gt(flag_gt), .pc_o(pc_o),
    .result_o(result_o), .mem_rdata(mem_rdata)
  );

  task automatic idle();
    pc_load = 0; addr_from_res = 0; mem_wr = 0; ir_load = 0; rf_wr = 0;
    dst_from_rd = 0; wb_from_mdr = 0; opa_from_reg = 0; opb_sel = 2'b00;
    pc_next_sel = 2'b00; alu_fn = 2'b00; init_wr = 0; init_addr = '0; init_data = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [3:0] v);
    return {{12{v[3]}}, v};
  endfunction

  function automatic logic [15:0] rdreg(input logic [3:0] i);
    return (i == 4'd0) ? 16'h0000 : m_rf[i];
  endfunction

  function automatic logic [15:0] alu_f(input logic [1:0] f, input logic [15:0] a, input logic [15:0] b);
    case (f)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [2:0] cmp_f(input logic [15:0] a, input logic [15:0] b);
    return {a == b, $signed(a) < $signed(b), $signed(a) > $signed(b)};
  endfunction

  // bench acts as the controller; opcodes: 0 hold, 1..4 add/sub/and/or,
  // 5 addi, 6 load, 7 store, 8..13 branches, 14 jump, 15 hold
  task automatic run_instr(input logic [15:0] w, input string tg = "R4 R6");
    logic [3:0]  opc, rs, rt, lo;
    logic [15:0] a, b, old, tgt, y;
    logic [7:0]  ad;
    logic [2:0]  fl;
    logic        taken;
    opc = w[15:12]; rs = w[11:8]; rt = w[7:4]; lo = w[3:0];
    // place the instruction at the current PC
    idle(); init_wr = 1; init_addr = m_pc[7:0]; init_data = w;
    cyc(); m_mem[m_pc[7:0]] = w;
    // fetch: memory read at old PC and PC+1 through the shared ALU on one edge
    idle(); ir_load = 1; pc_load = 1; opb_sel = 2'b01; pc_next_sel = 2'b00;
    cyc();
    old = m_pc; m_pc = old + 16'd1;
    chk("R2", {12'h000, opcode}, {12'h000, opc});
    chk("R3", pc_o, m_pc);
    chk("R5", result_o, old + 16'd1);
    // decode: branch target precomputed
    idle(); opb_sel = 2'b10;
    cyc();
    tgt = m_pc + sx(lo);
    a = rdreg(rs); b = rdreg(rt); fl = cmp_f(a, b);
    chk("R5", result_o, tgt);
    chk("R8", {13'h0, flag_eq, flag_lt, flag_gt}, {13'h0, fl});
    case (opc)
      4'd1, 4'd2, 4'd3, 4'd4: begin
        idle(); opa_from_reg = 1; opb_sel = 2'b00; alu_fn = 2'(opc - 4'd1);
        cyc(); y = alu_f(2'(opc - 4'd1), a, b);
        chk(tg, result_o, y);
        idle(); rf_wr = 1; dst_from_rd = 1;
        cyc(); m_rf[lo] = y;
      end
      4'd5: begin
        idle(); opa_from_reg = 1; opb_sel = 2'b10;
        cyc(); y = a + sx(lo);
        chk("R5", result_o, y);
        idle(); rf_wr = 1;
        cyc(); m_rf[rt] = y;
      end
      4'd6: begin
        idle(); opa_from_reg = 1; opb_sel = 2'b10;
        cyc(); y = a + sx(lo); ad = y[7:0];
        chk("R5", result_o, y);
        addr_from_res = 1;
        cyc();
        chk("R7", mem_rdata, m_mem[ad]);
        rf_wr = 1; wb_from_mdr = 1;
        cyc(); m_rf[rt] = m_mem[ad];
      end
      4'd7: begin
        idle(); opa_from_reg = 1; opb_sel = 2'b10;
        cyc(); y = a + sx(lo); ad = y[7:0];
        addr_from_res = 1; mem_wr = 1;
        cyc(); m_mem[ad] = b;
        chk("R7", mem_rdata, b);
      end
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13: begin
        case (opc)
          4'd8:    taken = fl[2];
          4'd9:    taken = !fl[2];
          4'd10:   taken = fl[1];
          4'd11:   taken = fl[1] | fl[2];
          4'd12:   taken = fl[0];
          default: taken = fl[0] | fl[2];
        endcase
        idle(); opa_from_reg = 1; opb_sel = 2'b00; alu_fn = 2'b01;
        pc_load = taken; pc_next_sel = 2'b01;
        cyc(); if (taken) m_pc = tgt;
        chk("R3", pc_o, m_pc);
        chk("R4", result_o, a - b);
      end
      4'd14: begin
        idle(); pc_load = 1; pc_next_sel = 2'b10;
        cyc(); m_pc = {4'h0, w[11:0]};
        chk("R3", pc_o, m_pc);
      end
      default: begin
        idle();
        cyc();
        chk("R11", pc_o, m_pc);
        chk("R11", {12'h000, opcode}, {12'h000, opc});
      end
    endcase
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    idle(); rst = 1; m_pc = '0;
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    @(negedge clk); cyc(); cyc();
    // R1: everything cleared
    chk("R1", pc_o, 16'h0000);
    chk("R1", result_o, 16'h0000);
    chk("R1", {12'h000, opcode}, 16'h0000);
    chk("R1", {13'h0, flag_eq, flag_lt, flag_gt}, 16'h0004);
    rst = 0;
    // R10: fill memory through the init port
    for (int i = 0; i < 256; i++) begin
      v = 16'($urandom);
      init_wr = 1; init_addr = 8'(i); init_data = v;
      cyc(); m_mem[i] = v;
    end
    idle(); cyc();
    chk("R10", mem_rdata, m_mem[0]);
    // load r1..r15 from memory (R9 write-back path)
    for (int i = 1; i < 16; i++) run_instr({4'd6, 4'd0, 4'(i), 4'(i)});
    for (int i = 1; i < 16; i++) run_instr({4'd1, 4'(i), 4'd0, 4'(i)}, "R9 R6");
    // R6: writes to register 0 are not visible
    run_instr({4'd5, 4'd0, 4'd0, 4'd5});
    run_instr({4'd1, 4'd0, 4'd0, 4'd1}, "R6");
    // R10: init write beats a same-cycle store at the same address
    idle(); mem_wr = 1; init_wr = 1; init_addr = m_pc[7:0]; init_data = 16'hC3A5;
    cyc(); m_mem[m_pc[7:0]] = 16'hC3A5; idle();
    chk("R10", mem_rdata, 16'hC3A5);
    // directed control flow: equal branch backwards, jump, hold
    run_instr({4'd8, 4'd3, 4'd3, 4'hE});
    run_instr({4'd14, 12'hABC});
    run_instr({4'd13, 4'd2, 4'd2, 4'h7});
    run_instr(16'h0123);
    run_instr({4'd1, 4'd4, 4'd0, 4'd6});
    // random stream
    for (int k = 0; k < 300; k++) run_instr(16'($urandom));
    run_instr(16'hF000);
    // R1: reset in mid-run
    rst = 1; cyc(); rst = 0;
    chk("R1", pc_o, 16'h0000);
    chk("R1", result_o, 16'h0000);
    chk("R1", {12'h000, opcode}, 16'h0000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule